// File: doc/BRIEF.md
# Isochronous Cycle Timer

This block keeps the 32-bit time base that an isochronous node uses to pace its 125 µs cycles. The register holds three fields: a cycle offset that advances once per period of the 24.576 MHz clock and wraps at 3072, a cycle count that wraps at 8000, and a 7-bit seconds count. Every time the cycle count advances, a one-clock strobe goes out.

A configuration input picks the source of the cycle count. A node that acts as cycle master sets it, and then the synchronized rising edge of an external 8 kHz pulse advances the count and clears the offset. A node that is not master clears it. The count then advances when the offset rolls over, and values taken from received cycle-start packets keep the register in phase with the master. A host can overwrite the whole register at any time. An enable input freezes the time base.

Top module: `iso_cycle_timer`

## Requirements
- R1: After reset, rd_data is 0 and cycle_out is 0. The offset sits in rd_data[11:0], the cycle count in rd_data[24:12] and the seconds in rd_data[31:25].
- R2: With ext_src low and enable high, the offset rises by one each clock. A step from an offset of 3071 sets the offset to 0 and raises the cycle count by one.
- R3: A cycle-count step from 7999 sets the count to 0 and raises the seconds by one. Seconds wrap from 127 to 0.
- R4: With ext_src high, a rising edge of cycle_in sets the offset to 0 and raises the cycle count. The result appears after the third rising clock edge that follows the change of the input. In this mode the offset still counts, but a wrap from 3071 to 0 leaves the cycle count unchanged.
- R5: With ext_src low, cycle_in has no effect on rd_data.
- R6: cycle_out is high for exactly the clock in which a new cycle count, produced by counting, first appears on rd_data. It stays low when the register is loaded by a write or by a cycle-start update.
- R7: With enable low and no load, rd_data holds and cycle_out stays low. cycle_in edges that arrive while enable is low are dropped.
- R8: wr_en loads all 32 bits of wr_data on the next edge. This wins over a same-cycle count step and works whatever the level of enable.
- R9: With ext_src low, cs_valid loads cs_value on the next edge and wins over a same-cycle wr_en.
- R10: With ext_src high, cs_valid has no effect, and a wr_en in the same cycle is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_src | input | 1 | 1: external 8 kHz pulse drives the cycle count (cycle master) |
| enable | input | 1 | Timer runs while high |
| cycle_in | input | 1 | External 8 kHz pulse, asynchronous |
| cs_valid | input | 1 | A received cycle-start value is presented |
| cs_value | input | 32 | Time value from the cycle-start packet |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write value |
| rd_data | output | 32 | Current register value |
| cycle_out | output | 1 | One-clock strobe when the cycle count advances |

## Verification
In internal mode the counter runs freely from zero across three full offset periods, and the bench compares every clock against an arithmetic model. This separates the offset modulus from a power-of-two wrap. Starting values loaded near the end of the offset, the cycle count and the seconds show whether carries ripple into the right field and at the right wrap points. In external mode, pulses held high for a long time and then repeated separate edge detection from level sensing, and also check the three-edge latency. Offset wraps with no pulse show that the count does not advance on a wrap in this mode. Clashes of write, cycle-start update, disable and pulse in the same cycle show the priority order.

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer #(
  parameter int OFF_W   = 12,
  parameter int CYC_W   = 13,
  parameter int SEC_W   = 7,
  parameter int OFF_MOD = 3072,
  parameter int CYC_MOD = 8000,
  localparam int TW = OFF_W + CYC_W + SEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_src,
  input  logic          enable,
  input  logic          cycle_in,
  input  logic          cs_valid,
  input  logic [TW-1:0] cs_value,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  output logic [TW-1:0] rd_data,
  output logic          cycle_out
);
  logic [OFF_W-1:0] off;
  logic [CYC_W-1:0] cyc;
  logic [SEC_W-1:0] sec;
  logic [2:0]       sync;

  wire in_rise  = sync[1] & ~sync[2];
  wire cs_take  = cs_valid & ~ext_src;
  wire off_last = off >= OFF_W'(OFF_MOD - 1);
  wire cyc_last = cyc >= CYC_W'(CYC_MOD - 1);
  wire bump     = ext_src ? in_rise : off_last;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], cycle_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off <= '0;
      cyc <= '0;
      sec <= '0;
      cycle_out <= 1'b0;
    end else begin
      cycle_out <= 1'b0;
      if (cs_take) begin
        {sec, cyc, off} <= cs_value;
      end else if (wr_en) begin
        {sec, cyc, off} <= wr_data;
      end else if (enable) begin
        off <= (bump || off_last) ? '0 : off + OFF_W'(1);
        if (bump) begin
          cycle_out <= 1'b1;
          cyc <= cyc_last ? '0 : cyc + CYC_W'(1);
          if (cyc_last) sec <= sec + SEC_W'(1);
        end
      end
    end
  end

  assign rd_data = {sec, cyc, off};
endmodule

// File: rtl/iso_cycle_timer_chk.sv
module iso_cycle_timer_chk #(
  parameter int OFF_W   = 12,
  parameter int CYC_W   = 13,
  parameter int SEC_W   = 7,
  parameter int OFF_MOD = 3072,
  parameter int CYC_MOD = 8000,
  localparam int TW = OFF_W + CYC_W + SEC_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_src,
  input logic          enable,
  input logic          cs_valid,
  input logic [TW-1:0] cs_value,
  input logic          wr_en,
  input logic [TW-1:0] wr_data,
  input logic [TW-1:0] rd_data,
  input logic          cycle_out
);
  wire cs_hit = cs_valid && !ext_src;
  wire step   = enable && !wr_en && !cs_hit;
  wire [OFF_W-1:0] c_off = rd_data[OFF_W-1:0];
  wire [CYC_W-1:0] c_cyc = rd_data[OFF_W +: CYC_W];

  assert_cs_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hit |=> rd_data == $past(cs_value));

  assert_wr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cs_hit) |=> rd_data == $past(wr_data));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_en && !cs_hit) |=> ($stable(rd_data) && !cycle_out));

  assert_pulse_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_out |-> c_off == '0);

  assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> c_off < OFF_W'(OFF_MOD));

  assert_cycle_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && c_cyc < CYC_W'(CYC_MOD)) |=> c_cyc < CYC_W'(CYC_MOD));
endmodule

bind iso_cycle_timer iso_cycle_timer_chk #(
  .OFF_W(OFF_W), .CYC_W(CYC_W), .SEC_W(SEC_W), .OFF_MOD(OFF_MOD), .CYC_MOD(CYC_MOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_src(ext_src), .enable(enable),
  .cs_valid(cs_valid), .cs_value(cs_value), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .cycle_out(cycle_out)
);

// File: tb/sim_iso_cycle_timer.sv
module sim_iso_cycle_timer;
  logic clk = 1'b0, rst_n = 1'b0, ext_src = 1'b0, enable = 1'b0, cycle_in = 1'b0;
  logic cs_valid = 1'b0, wr_en = 1'b0;
  logic [31:0] cs_value = '0, wr_data = '0;
  logic [31:0] rd_data;
  logic cycle_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iso_cycle_timer u0 (
    .clk(clk), .rst_n(rst_n), .ext_src(ext_src), .enable(enable), .cycle_in(cycle_in),
    .cs_valid(cs_valid), .cs_value(cs_value), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cycle_out(cycle_out)
  );

  function automatic logic [31:0] tv(int s, int c, int o);
    return {s[6:0], c[12:0], o[11:0]};
  endfunction

  function automatic logic [31:0] adv(logic [31:0] v, int k);
    int o = int'(v[11:0]) + k;
    int c = int'(v[24:12]) + o / 3072;
    int s = int'(v[31:25]) + c / 8000;
    return tv(s % 128, c % 8000, o % 3072);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_model(logic [31:0] v, int n, string req);
    load(v);
    chk(rd_data == v, "R8", rd_data, v);
    chk(cycle_out == 1'b0, "R6", {31'd0, cycle_out}, 32'd0);
    for (int k = 1; k <= n; k++) begin
      logic [31:0] e, p;
      @(negedge clk);
      e = adv(v, k);
      p = adv(v, k - 1);
      chk(rd_data == e, req, rd_data, e);
      chk(cycle_out == (e[24:12] != p[24:12]), "R6", {31'd0, cycle_out},
          {31'd0, e[24:12] != p[24:12]});
    end
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(rd_data == 32'd0, "R1", rd_data, 32'd0);
    chk(cycle_out == 1'b0, "R1", {31'd0, cycle_out}, 32'd0);
    rst_n = 1'b1;
    enable = 1'b1;

    // R2: free run from zero across three offset periods
    run_model(32'd0, 3 * 3072 + 5, "R2");
    // R3: carries into seconds and seconds wrap
    run_model(tv(3, 7998, 3000), 200, "R3");
    run_model(tv(127, 7999, 3060), 20, "R3");
    for (int o = 3064; o < 3072; o++) run_model(tv(1, 42, o), 12, "R2");

    // R5: cycle_in ignored in internal mode
    load(tv(0, 20, 10));
    cycle_in = 1'b1; @(negedge clk); cycle_in = 1'b0; @(negedge clk);
    cycle_in = 1'b1; repeat (3) @(negedge clk);
    chk(rd_data == tv(0, 20, 15), "R5", rd_data, tv(0, 20, 15));
    cycle_in = 1'b0; repeat (3) @(negedge clk);

    // R4: external source, latency and edge (not level) sensitivity
    ext_src = 1'b1;
    load(tv(2, 5, 100));
    cycle_in = 1'b1;
    @(negedge clk); chk(rd_data == tv(2, 5, 101), "R4", rd_data, tv(2, 5, 101));
    @(negedge clk); chk(rd_data == tv(2, 5, 102), "R4", rd_data, tv(2, 5, 102));
    @(negedge clk); chk(rd_data == tv(2, 6, 0), "R4", rd_data, tv(2, 6, 0));
    chk(cycle_out == 1'b1, "R6", {31'd0, cycle_out}, 32'd1);
    @(negedge clk); chk(cycle_out == 1'b0, "R6", {31'd0, cycle_out}, 32'd0);
    repeat (6) @(negedge clk);
    chk(rd_data == tv(2, 6, 7), "R4", rd_data, tv(2, 6, 7));
    cycle_in = 1'b0; @(negedge clk);
    cycle_in = 1'b1; repeat (3) @(negedge clk);
    chk(rd_data == tv(2, 7, 0), "R4", rd_data, tv(2, 7, 0));
    cycle_in = 1'b0;
    // R4: offset wrap in external mode leaves count alone
    load(tv(0, 9, 3070));
    @(negedge clk); chk(rd_data == tv(0, 9, 3071), "R4", rd_data, tv(0, 9, 3071));
    @(negedge clk); chk(rd_data == tv(0, 9, 0), "R4", rd_data, tv(0, 9, 0));
    chk(cycle_out == 1'b0, "R6", {31'd0, cycle_out}, 32'd0);
    // R7: disabled, pulse is dropped
    load(tv(1, 1, 1));
    enable = 1'b0;
    cycle_in = 1'b1; repeat (6) @(negedge clk);
    chk(rd_data == tv(1, 1, 1), "R7", rd_data, tv(1, 1, 1));
    chk(cycle_out == 1'b0, "R7", {31'd0, cycle_out}, 32'd0);
    enable = 1'b1; @(negedge clk);
    chk(rd_data == tv(1, 1, 2), "R7", rd_data, tv(1, 1, 2));
    cycle_in = 1'b0;
    // R10: cycle-start ignored in external mode; write applies alongside
    enable = 1'b0;
    @(negedge clk); held = rd_data;
    cs_valid = 1'b1; cs_value = tv(9, 9, 9);
    @(negedge clk); chk(rd_data == held, "R10", rd_data, held);
    wr_en = 1'b1; wr_data = tv(4, 4, 4);
    @(negedge clk); wr_en = 1'b0; cs_valid = 1'b0;
    chk(rd_data == tv(4, 4, 4), "R10", rd_data, tv(4, 4, 4));

    // R8: write while disabled holds; R9: cycle-start wins over write
    ext_src = 1'b0;
    load(tv(6, 7000, 500));
    repeat (4) @(negedge clk);
    chk(rd_data == tv(6, 7000, 500), "R8", rd_data, tv(6, 7000, 500));
    enable = 1'b1;
    @(negedge clk);
    cs_valid = 1'b1; cs_value = tv(11, 300, 3071);
    wr_en = 1'b1; wr_data = tv(1, 2, 3);
    @(negedge clk); cs_valid = 1'b0; wr_en = 1'b0;
    chk(rd_data == tv(11, 300, 3071), "R9", rd_data, tv(11, 300, 3071));
    chk(cycle_out == 1'b0, "R6", {31'd0, cycle_out}, 32'd0);
    @(negedge clk);
    chk(rd_data == tv(11, 301, 0), "R9", rd_data, tv(11, 301, 0));
    chk(cycle_out == 1'b1, "R6", {31'd0, cycle_out}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule